// File: doc/BRIEF.md
# Randomized Core Clock Gate

This block turns a fast external clock into a sparse, unpredictable stream of core clock enables. Each external cycle, it combines independent random bits. The processor core advances only on cycles where every one of those bits is set. With two bits, a core step happens on about one external cycle in four.

The timer and the serial I/O logic are not subject to this lottery. They receive an enable that stays high on every cycle once reset is released. On each cycle where the core rests, the block raises a dummy-load enable instead. This keeps the supply current about the same whether or not the core steps, so the current profile does not reveal the random pattern.

The random bits come either from an input port or from an internal linear feedback shift register, chosen by a parameter. A saturating counter of core steps lets the step density be measured over a window of external cycles.

Top module: `rclk_gate`

## Requirements
- R1: With the external random source selected, `core_en` is high in the cycle after an edge that sampled `rnd_bits` = 2'b11.
- R2: With the external random source selected, `core_en` is low in the cycle after an edge that sampled `rnd_bits` equal to 2'b00, 2'b01 or 2'b10.
- R3: Once `periph_en` is high, `dummy_load` is always the complement of `core_en`, so exactly one of the two is active in each cycle.
- R4: `periph_en` is high on every cycle from the first clock edge after reset release.
- R5: While `rst_n` is low, `core_en`, `dummy_load` and `periph_en` are low and `core_cycles` is zero. Reset takes effect without waiting for a clock edge.
- R6: `core_cycles` rises by exactly one at each clock edge where `core_en` was high, and is unchanged at every other edge.
- R7: `core_cycles` saturates at 65535 (all ones, 16 bits) and stays there while `core_en` keeps firing.
- R8: With the internal shift-register source selected, the `core_cycles` value 1000 cycles after reset release lies between 180 and 320.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast external clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rnd_bits | input | SEL_BITS (2) | Random bits from an external generator. Ignored when the internal source is selected. |
| core_en | output | 1 | Core clock enable for this cycle |
| dummy_load | output | 1 | Dummy-load enable, active on core rest cycles |
| periph_en | output | 1 | Enable for the timer and I/O shift register, high on every cycle |
| core_cycles | output | CNT_W (16) | Saturating count of core enable cycles |

## Verification
All four values of the two random bits are applied one at a time, both in steady runs and in alternating runs. This separates an AND of the bits from an OR or a single-bit tap, and it shows whether the enable lags the sampled bits by exactly one cycle.

A long run with both bits set drives the step counter to its ceiling, which tests saturation. A mid-run reset checks that every output clears at once.

A second instance uses the internal shift-register source. It runs for 1000 cycles, and its step count is checked against the one-in-four density band.

// File: rtl/rclk_gate_pkg.sv
package rclk_gate_pkg;
    typedef struct packed {
        logic core_en;
        logic dummy;
        logic periph_en;
    } gate_state_t;

    localparam gate_state_t GATE_IDLE = '{core_en: 1'b0, dummy: 1'b0, periph_en: 1'b0};
endpackage

// File: rtl/rclk_rand_src.sv
module rclk_rand_src #(
    parameter int              SEL_BITS = 2,
    parameter bit              USE_LFSR = 1'b0,
    parameter int              LFSR_W   = 16,
    parameter logic [LFSR_W-1:0] TAPS   = 16'hB400,
    parameter logic [LFSR_W-1:0] SEED   = 16'hACE1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SEL_BITS-1:0] ext_bits,
    output logic [SEL_BITS-1:0] bits_o
);
    generate
        if (USE_LFSR) begin : g_lfsr
            logic [LFSR_W-1:0]   lfsr_d, lfsr_q;
            logic [SEL_BITS-1:0] out_d;

            always_comb begin
                logic [LFSR_W-1:0] s;
                s     = lfsr_q;
                out_d = '0;
                for (int i = 0; i < SEL_BITS; i++) begin
                    out_d[i] = s[0];
                    s        = s[0] ? ((s >> 1) ^ TAPS) : (s >> 1);
                end
                lfsr_d = s;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) lfsr_q <= SEED;
                else        lfsr_q <= lfsr_d;
            end

            assign bits_o = out_d;
        end else begin : g_ext
            assign bits_o = ext_bits;
        end
    endgenerate
endmodule

// File: rtl/rclk_sat_cnt.sv
module rclk_sat_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && (cnt_q != CNT_MAX)) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/rclk_gate.sv
module rclk_gate
    import rclk_gate_pkg::*;
#(
    parameter int SEL_BITS = 2,
    parameter int CNT_W    = 16,
    parameter bit USE_LFSR = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SEL_BITS-1:0] rnd_bits,
    output logic                core_en,
    output logic                dummy_load,
    output logic                periph_en,
    output logic [CNT_W-1:0]    core_cycles
);
    logic [SEL_BITS-1:0] src_bits;
    gate_state_t         st_d, st_q;

    rclk_rand_src #(.SEL_BITS(SEL_BITS), .USE_LFSR(USE_LFSR)) i_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_bits (rnd_bits),
        .bits_o   (src_bits)
    );

    // Core steps only when every random bit is set: density 2^-SEL_BITS.
    always_comb begin
        st_d.core_en   = &src_bits;
        st_d.dummy     = ~(&src_bits);
        st_d.periph_en = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= GATE_IDLE;
        else        st_q <= st_d;
    end

    rclk_sat_cnt #(.CNT_W(CNT_W)) i_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (st_q.core_en),
        .count_o (core_cycles)
    );

    assign core_en    = st_q.core_en;
    assign dummy_load = st_q.dummy;
    assign periph_en  = st_q.periph_en;
endmodule

// File: rtl/rclk_gate_chk.sv
module rclk_gate_chk #(
    parameter int SEL_BITS = 2,
    parameter int CNT_W    = 16,
    parameter bit USE_LFSR = 1'b0
) (
    input logic                clk,
    input logic                rst_n,
    input logic [SEL_BITS-1:0] rnd_bits,
    input logic                core_en,
    input logic                dummy_load,
    input logic                periph_en,
    input logic [CNT_W-1:0]    core_cycles
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam bit EXT_SRC = (USE_LFSR == 1'b0);

    assert_all_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (EXT_SRC && (&rnd_bits)) |=> core_en);

    assert_not_all_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (EXT_SRC && !(&rnd_bits)) |=> !core_en);

    assert_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        periph_en |-> (dummy_load != core_en));

    assert_periph_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        periph_en |=> periph_en);

    // R5: checked at every edge while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_idle_R5: assert (!core_en && !dummy_load && !periph_en && core_cycles == '0);
        end
    end

    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (core_en && core_cycles != CNT_MAX) |=> (core_cycles == $past(core_cycles) + 1'b1));

    assert_count_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !core_en |=> $stable(core_cycles));

    assert_count_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (core_cycles == CNT_MAX) |=> (core_cycles == CNT_MAX));
endmodule

bind rclk_gate rclk_gate_chk #(.SEL_BITS(SEL_BITS), .CNT_W(CNT_W), .USE_LFSR(USE_LFSR)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rnd_bits    (rnd_bits),
    .core_en     (core_en),
    .dummy_load  (dummy_load),
    .periph_en   (periph_en),
    .core_cycles (core_cycles)
);

// File: tb/test_rclk_gate.sv
`timescale 1ns/1ps
module test_rclk_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rst_l_n = 1'b0;
    logic [1:0]  rnd = 2'b00;
    logic        core_en, dummy_load, periph_en;
    logic [15:0] core_cycles;
    logic        l_core_en, l_dummy, l_periph;
    logic [15:0] l_cycles;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    // Model of the expected state
    bit          exp_en = 1'b0;
    int          exp_cnt = 0;

    always #2.5 clk = ~clk;

    rclk_gate i_rclk_gate (
        .clk(clk), .rst_n(rst_n), .rnd_bits(rnd),
        .core_en(core_en), .dummy_load(dummy_load),
        .periph_en(periph_en), .core_cycles(core_cycles)
    );

    rclk_gate #(.USE_LFSR(1'b1)) i_rclk_gate_lfsr (
        .clk(clk), .rst_n(rst_l_n), .rnd_bits(2'b00),
        .core_en(l_core_en), .dummy_load(l_dummy),
        .periph_en(l_periph), .core_cycles(l_cycles)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive one bit pair, let one edge pass, compare at the next negedge.
    task automatic step(input logic [1:0] b);
        rnd = b;
        @(posedge clk);
        if (exp_en && exp_cnt != 65535) exp_cnt++;
        exp_en = (b == 2'b11);
        @(negedge clk);
        check(exp_en ? "R1" : "R2", "core_en", int'(core_en), int'(exp_en));
        check("R3", "dummy_load", int'(dummy_load), int'(!exp_en));
        check("R4", "periph_en", int'(periph_en), 1);
        check("R6", "core_cycles", int'(core_cycles), exp_cnt);
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        check("R5", "reset core_en", int'(core_en), 0);
        check("R5", "reset dummy_load", int'(dummy_load), 0);
        check("R5", "reset periph_en", int'(periph_en), 0);
        check("R5", "reset core_cycles", int'(core_cycles), 0);
        rst_n = 1'b1;
        exp_en = 1'b0;
        exp_cnt = 0;
    endtask

    task automatic t_patterns();
        step(2'b00); step(2'b01); step(2'b10); step(2'b11);
        step(2'b11); step(2'b11); step(2'b00); step(2'b11);
        step(2'b01); step(2'b11); step(2'b10); step(2'b10);
    endtask

    task automatic t_mid_reset();
        step(2'b11); step(2'b11);
        rst_n = 1'b0;
        #1;
        check("R5", "async core_en", int'(core_en), 0);
        check("R5", "async dummy_load", int'(dummy_load), 0);
        check("R5", "async periph_en", int'(periph_en), 0);
        check("R5", "async core_cycles", int'(core_cycles), 0);
        @(negedge clk);
        rst_n = 1'b1;
        exp_en = 1'b0;
        exp_cnt = 0;
        step(2'b11); step(2'b00);
    endtask

    task automatic t_saturate();
        rnd = 2'b11;
        repeat (65540) @(posedge clk);
        exp_en = 1'b1;
        exp_cnt = 65535;
        @(negedge clk);
        check("R7", "saturated count", int'(core_cycles), 65535);
        step(2'b11);
        step(2'b11);
        check("R7", "count held at max", int'(core_cycles), 65535);
    endtask

    task automatic t_lfsr_density();
        @(negedge clk);
        rst_l_n = 1'b1;
        repeat (1000) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (l_cycles < 180 || l_cycles > 320) begin
            n_errors++;
            $display("FAIL R8 density: actual=%0d expected=180..320", l_cycles);
        end
        check("R3", "lfsr dummy complement", int'(l_dummy), int'(!l_core_en));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset_state();
        t_patterns();
        t_mid_reset();
        t_lfsr_density();
        t_saturate();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #(5ns * 150000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule